// File: doc/BRIEF.md
# Bit-Reversed Deletion Distributor

This block spreads a programmable number of one-cycle deletion requests across a fixed window of divider resets. It is meant to sit beside an integer divide-by-N counter. Each deletion request makes that counter hold for one extra input cycle, so the mean modulus becomes N plus a fraction whose numerator is held in a vernier register.

The vernier register is moved one step at a time by command pulses, with a direction input. A free-running comparison counter advances on every divider-reset strobe. Each vernier bit is paired with one bit of the comparison counter, taken in reversed significance. The result is that each binary weight produces its own evenly spaced train of deletions, and the trains are ORed into one request.

When the vernier steps past its top value it wraps and emits a carry pulse. When it steps below zero it wraps and emits a borrow pulse. Both pulses are meant to move the integer modulus register by one.

Top module: `deletion_spreader`

## Requirements
- R1: After reset the vernier value and the comparison counter are both zero, and no deletion, carry or borrow is raised.
- R2: The comparison counter advances by exactly one, modulo 2^W, in each cycle where the strobe input is high, and holds otherwise. A window is 2^W strobes.
- R3: The deletion output is high only in a cycle where the strobe input is high. It is combinational in that cycle.
- R4: Let c be the comparison count after the current strobe. Vernier bit k requests a deletion when c is nonzero and the lowest set bit of c is at position W-1-k.
- R5: Over any 2^W consecutive strobes with no command pulses, the number of deletions equals the vernier value.
- R6: A vernier value of 2^m-1 gives deletions exactly at the new counts that are nonzero multiples of 2^(W-m).
- R7: A strobe that brings the comparison counter to zero never raises a deletion.
- R8: A command pulse with the direction input high adds one to the vernier value. With the direction input low it subtracts one. The change is visible from the next cycle.
- R9: An up pulse while the vernier value is all ones wraps it to zero and raises the carry output in that same cycle.
- R10: A down pulse while the vernier value is zero wraps it to all ones and raises the borrow output in that same cycle.
- R11: Without command pulses the vernier value holds, whatever the strobe does.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| div_strobe_i | input | 1 | One-cycle pulse per divider reset |
| cmd_pulse_i | input | 1 | One-cycle vernier step command |
| cmd_up_i | input | 1 | Step direction: 1 up, 0 down |
| delete_o | output | 1 | Deletion request, aligned to the strobe |
| carry_o | output | 1 | Vernier wrapped upward |
| borrow_o | output | 1 | Vernier wrapped downward |

## Verification
The bench uses a narrow W=8 instance so that whole windows fit in the run. With a zero vernier it confirms that nothing fires. With a single low weight it shows that idle cycles leave the counter phase untouched. With 63 set it checks the exact deletion positions, which separates a bit-reversed pairing from a straight one. Random vernier values are then reached by random command bursts and measured over windows with random gaps between strobes. A wrong total in such a window points at a lost weight or a drifting vernier. Walking down through zero and back up past the top exercises the borrow and carry wraps.

// File: rtl/dd_pkg.sv
package dd_pkg;
   typedef enum logic {
      DIR_DOWN = 1'b0,
      DIR_UP   = 1'b1
   } dd_dir_e;

   localparam int unsigned DD_MIN_W = 2;
   localparam int unsigned DD_MAX_W = 32;
endpackage

// File: rtl/dd_vernier.sv
module dd_vernier #(
   parameter int unsigned W = 20
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic         step_i,
   input  logic         up_i,
   output logic [W-1:0] value_o,
   output logic         carry_o,
   output logic         borrow_o
);
   import dd_pkg::*;

   localparam logic [W-1:0] TOP = {W{1'b1}};
   localparam logic [W-1:0] ONE = {{(W-1){1'b0}}, 1'b1};

   dd_dir_e      dir;
   logic [W-1:0] value_q;
   logic         at_top;
   logic         at_bot;

   assign dir    = dd_dir_e'(up_i);
   assign at_top = (value_q == TOP);
   assign at_bot = (value_q == '0);

   assign carry_o  = step_i && (dir == DIR_UP)   && at_top;
   assign borrow_o = step_i && (dir == DIR_DOWN) && at_bot;
   assign value_o  = value_q;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         value_q <= '0;
      end else if (step_i) begin
         if (dir == DIR_UP) value_q <= value_q + ONE;
         else               value_q <= value_q - ONE;
      end
   end

   AST_VERN_UP:     assert property (@(posedge clk) disable iff (!rst_n)
      (step_i && up_i) |=> (value_o == $past(value_o) + ONE));   // R8
   AST_VERN_DOWN:   assert property (@(posedge clk) disable iff (!rst_n)
      (step_i && !up_i) |=> (value_o == $past(value_o) - ONE));  // R8
   AST_CARRY_WRAP:  assert property (@(posedge clk) disable iff (!rst_n)
      carry_o |=> (value_o == '0));                              // R9
   AST_BORROW_WRAP: assert property (@(posedge clk) disable iff (!rst_n)
      borrow_o |=> (value_o == TOP));                            // R10
   AST_VERN_HOLD:   assert property (@(posedge clk) disable iff (!rst_n)
      !step_i |=> $stable(value_o));                             // R11
endmodule

// File: rtl/dd_cmp_ctr.sv
module dd_cmp_ctr #(
   parameter int unsigned W = 20
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic         adv_i,
   output logic [W-1:0] next_o
);
   localparam logic [W-1:0] ONE = {{(W-1){1'b0}}, 1'b1};

   logic [W-1:0] cnt_q;

   assign next_o = cnt_q + ONE;

   always_ff @(posedge clk) begin
      if (!rst_n)     cnt_q <= '0;
      else if (adv_i) cnt_q <= next_o;
   end

   AST_CMP_STEP: assert property (@(posedge clk) disable iff (!rst_n)
      adv_i |=> (cnt_q == $past(cnt_q) + ONE));   // R2
   AST_CMP_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
      !adv_i |=> $stable(cnt_q));                 // R2
endmodule

// File: rtl/dd_match.sv
module dd_match #(
   parameter int unsigned W             = 20,
   parameter bit          ARITH_ISOLATE = 1'b1
) (
   input  logic         strobe_i,
   input  logic [W-1:0] cmp_next_i,
   input  logic [W-1:0] vern_i,
   output logic         hit_o
);
   logic [W-1:0] low1;
   logic [W-1:0] lane;

   generate
      if (ARITH_ISOLATE) begin : g_arith
         assign low1 = cmp_next_i & (~cmp_next_i + {{(W-1){1'b0}}, 1'b1});
      end else begin : g_scan
         always_comb begin
            logic found;
            found = 1'b0;
            low1  = '0;
            for (int i = 0; i < W; i++) begin
               if (cmp_next_i[i] && !found) begin
                  low1[i] = 1'b1;
                  found   = 1'b1;
               end
            end
         end
      end
   endgenerate

   generate
      for (genvar k = 0; k < W; k++) begin : g_lane
         assign lane[k] = vern_i[k] & low1[W-1-k];
      end
   endgenerate

   assign hit_o = strobe_i & (|lane);
endmodule

// File: rtl/deletion_spreader.sv
module deletion_spreader #(
   parameter int unsigned W             = 20,
   parameter bit          ARITH_ISOLATE = 1'b1
) (
   input  logic clk,
   input  logic rst_n,
   input  logic div_strobe_i,
   input  logic cmd_pulse_i,
   input  logic cmd_up_i,
   output logic delete_o,
   output logic carry_o,
   output logic borrow_o
);
   import dd_pkg::*;

   generate
      if (W < DD_MIN_W || W > DD_MAX_W) begin : g_bad_width
         $error("deletion_spreader: W out of supported range");
      end
   endgenerate

   logic [W-1:0] vern;
   logic [W-1:0] cmp_next;

   dd_vernier #(.W(W)) u_vern (
      .clk      (clk),
      .rst_n    (rst_n),
      .step_i   (cmd_pulse_i),
      .up_i     (cmd_up_i),
      .value_o  (vern),
      .carry_o  (carry_o),
      .borrow_o (borrow_o)
   );

   dd_cmp_ctr #(.W(W)) u_cmp (
      .clk    (clk),
      .rst_n  (rst_n),
      .adv_i  (div_strobe_i),
      .next_o (cmp_next)
   );

   dd_match #(.W(W), .ARITH_ISOLATE(ARITH_ISOLATE)) u_match (
      .strobe_i   (div_strobe_i),
      .cmp_next_i (cmp_next),
      .vern_i     (vern),
      .hit_o      (delete_o)
   );

   AST_DEL_NEEDS_STROBE: assert property (@(posedge clk) disable iff (!rst_n)
      delete_o |-> div_strobe_i);                                // R3
   AST_ZERO_SILENT:      assert property (@(posedge clk) disable iff (!rst_n)
      (div_strobe_i && cmp_next == '0) |-> !delete_o);           // R7
   AST_NO_VERN_NO_DEL:   assert property (@(posedge clk) disable iff (!rst_n)
      (vern == '0) |-> !delete_o);                               // R4
   AST_WRAP_EXCLUSIVE:   assert property (@(posedge clk) disable iff (!rst_n)
      !(carry_o && borrow_o));                                   // R9
endmodule

// File: tb/deletion_spreader_bench.sv
`timescale 1ns/1ps
module deletion_spreader_bench;
   localparam int BW  = 8;
   localparam int NW  = 1 << BW;
   localparam int MAX = NW - 1;

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic strobe = 1'b0;
   logic pulse = 1'b0;
   logic up = 1'b0;
   logic delete_o, carry_o, borrow_o;

   int tests = 0;
   int fails = 0;
   int vern_m = 0;
   int cnt_m = 0;
   int win = 0;
   bit r6_mode = 1'b0;
   bit done = 1'b0;

   always #2.5 clk = ~clk;

   deletion_spreader #(.W(BW)) u_deletion_spreader (
      .clk          (clk),
      .rst_n        (rst_n),
      .div_strobe_i (strobe),
      .cmd_pulse_i  (pulse),
      .cmd_up_i     (up),
      .delete_o     (delete_o),
      .carry_o      (carry_o),
      .borrow_o     (borrow_o)
   );

   function automatic bit exp_del(int v, int n);
      int tz;
      if (n == 0) return 1'b0;
      tz = 0;
      while (((n >> tz) & 1) == 0) tz++;
      return ((v >> (BW - 1 - tz)) & 1) == 1;
   endfunction

   task automatic chk(bit ok, string req, int act, int expv);
      tests++;
      if (!ok) begin
         fails++;
         $display("FAIL %s: actual %0d expected %0d", req, act, expv);
      end
   endtask

   task automatic cyc(bit s, bit p, bit u);
      int n;
      bit ed, ec, eb;
      @(negedge clk);
      strobe = s; pulse = p; up = u;
      #1;
      n  = (cnt_m + 1) % NW;
      ed = s && exp_del(vern_m, n);
      ec = p && u && (vern_m == MAX);
      eb = p && !u && (vern_m == 0);
      if (!s)          chk(delete_o == 1'b0, "R3", int'(delete_o), 0);
      else if (n == 0) chk(delete_o == 1'b0, "R7", int'(delete_o), 0);
      else             chk(delete_o == ed,   "R4", int'(delete_o), int'(ed));
      if (r6_mode && s)
         chk(delete_o == (n != 0 && (n % (1 << (BW - 6))) == 0), "R6",
             int'(delete_o), int'(n != 0 && (n % (1 << (BW - 6))) == 0));
      chk(carry_o == ec,  "R9",  int'(carry_o),  int'(ec));
      chk(borrow_o == eb, "R10", int'(borrow_o), int'(eb));
      if (delete_o) win++;
      if (s) cnt_m = n;
      if (p) vern_m = u ? (vern_m + 1) % NW : (vern_m + NW - 1) % NW;
   endtask

   task automatic run_window(int gap_max, string req);
      win = 0;
      for (int i = 0; i < NW; i++) begin
         int g;
         g = (gap_max == 0) ? 0 : int'($urandom % (gap_max + 1));
         for (int j = 0; j < g; j++) cyc(1'b0, 1'b0, 1'b0);
         cyc(1'b1, 1'b0, 1'b0);
      end
      chk(win == vern_m, req, win, vern_m);
   endtask

   initial begin
      void'($urandom(32'd20240611));
      repeat (3) @(negedge clk);
      @(negedge clk);
      rst_n = 1'b1;
      #1;
      // R1: quiet outputs out of reset
      chk(delete_o == 0 && carry_o == 0 && borrow_o == 0, "R1",
          int'({delete_o, carry_o, borrow_o}), 0);
      run_window(0, "R1");

      // R2: idle cycles must not move the counter; vern=1 fires only at count 128
      cyc(1'b1, 1'b1, 1'b1);  // first strobe of the phase, vern -> 1 after
      for (int i = 0; i < 126; i++) begin
         cyc(1'b0, 1'b0, 1'b0);
         cyc(1'b1, 1'b0, 1'b0);
         chk(delete_o == 1'b0, "R2", int'(delete_o), 0);
      end
      cyc(1'b0, 1'b0, 1'b0);
      cyc(1'b1, 1'b0, 1'b0);
      chk(delete_o == 1'b1, "R2", int'(delete_o), 1);
      for (int i = 0; i < 128; i++) cyc(1'b1, 1'b0, 1'b0);

      // R8: climb to 63, then R6 spacing over one window
      for (int i = 0; i < 62; i++) cyc(1'b0, 1'b1, 1'b1);
      chk(vern_m == 63, "R8", vern_m, 63);
      r6_mode = 1'b1;
      run_window(0, "R6");
      r6_mode = 1'b0;

      // R10: walk down through zero
      for (int i = 0; i < 63; i++) cyc(1'b1, 1'b1, 1'b0);
      cyc(1'b0, 1'b1, 1'b0);
      chk(vern_m == MAX, "R10", vern_m, MAX);
      run_window(2, "R5");
      // R9: wrap back upward
      cyc(1'b1, 1'b1, 1'b1);
      run_window(1, "R11");

      // random command bursts then windows with random strobe gaps
      for (int it = 0; it < 20; it++) begin
         int nc;
         nc = int'($urandom % 60);
         for (int j = 0; j < nc; j++)
            cyc(1'($urandom % 2), 1'b1, 1'($urandom % 4 != 0));
         run_window(3, "R5");
      end

      done = 1'b1;
      $display("[TB] %0d tests run, %0d failed", tests, fails);
      $finish;
   end

   initial begin
      repeat (150000) @(posedge clk);
      if (!done) begin
         tests++;
         fails++;
         $display("FAIL watchdog: actual %0d expected %0d", 1, 0);
         $display("[TB] %0d tests run, %0d failed", tests, fails);
         $finish;
      end
   end
endmodule